// File: doc/BRIEF.md
# Keyed Page Programming Sequencer

This block commits data into an on-chip nonvolatile store one page at a time on behalf of a CPU register interface. Software first writes bytes into a page-sized column-latch buffer. Each byte is placed by the low address bits, and the high address bits pick the target page. Software then writes a two-step key into the upper nibble of a control register. When the key completes, a sequencer walks the buffer. It writes every loaded byte into the chosen space, waits a programmable number of clock cycles that stand in for the cell write time, and then empties the buffer.

Three spaces can be targeted. The first is a 2 KB main array, which holds 16 pages of 128 bytes. The second is one extra row of 128 bytes. The third is a single security byte. The main array is modelled as a synchronous RAM. A read port returns any byte of any space one cycle after it is addressed. A busy output stays high for the whole programming operation. While it is high, the buffer and the key logic accept nothing.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, `busy` is 0 and the security byte reads FFh.
- R2: Programming starts when a control write with upper nibble 5h is followed, as the next control write, by one with upper nibble Ah. `busy` is 1 after the clock edge that samples the Ah write.
- R3: A control write whose upper nibble is 5h always arms the key. Any other nibble disarms it, except an Ah that launches. An Ah write with no armed key does not launch, and neither does an Ah that follows a 5h and then some other value. The sequence 5h, 5h, Ah does launch.
- R4: Only latch bytes loaded since the last launch are written. Every other byte of the target page keeps its old value.
- R5: A latch load places `ld_data` at byte index `ld_addr[6:0]`. The page that is programmed is `ld_addr[10:7]` of the last accepted load before the launch, and this also applies to bytes that were loaded with a different page.
- R6: Bits [1:0] of the launching write select the space. 00 and 11 select the main array, 01 selects the extra row, and 10 selects the security byte. The security byte takes only latch byte 0.
- R7: `busy` stays high for exactly 128 + W + 1 clock cycles, where W is `prog_wait` sampled at the launch edge.
- R8: While `busy` is 1, latch loads and control writes, including key nibbles, are ignored.
- R9: When programming ends, all latch bytes become unloaded. A following launch with no new loads changes no byte.
- R10: `rd_data` shows the byte selected by `rd_sel` (encoded as in R6) and `rd_addr` one clock after they are applied. The extra row uses `rd_addr[6:0]`.
- R11: A latch load sampled at the same edge as the launching Ah write is part of that programming operation, including its page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control byte: key nibble [7:4], space select [1:0] |
| ld_we | input | 1 | Latch load strobe |
| ld_addr | input | 11 | Load address: page [10:7], byte index [6:0] |
| ld_data | input | 8 | Byte to load into the latch |
| prog_wait | input | 16 | Extra wait cycles before completion |
| rd_sel | input | 2 | Read space select |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Read data, one cycle latency |
| busy | output | 1 | Programming in progress |

## Verification
A latch load and the launching key write can reach the block at the same clock edge. The bench provokes this by driving `ld_we` together with the Ah control write. It then reads back the target page and expects the simultaneous byte to be present, on the page carried by that same load. The bench also aims loads and a 5h key nibble into the busy window of an operation. After busy drops it confirms, through read-back and the absence of a new busy pulse, that neither had any effect.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  typedef enum logic [1:0] {
    SP_USER = 2'b00,
    SP_XROW = 2'b01,
    SP_SEC  = 2'b10,
    SP_ALT  = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_e;

  localparam logic [3:0] KEY_ARM = 4'h5;
  localparam logic [3:0] KEY_GO  = 4'hA;
endpackage

// File: rtl/nvm_key_unlock.sv
module nvm_key_unlock
  import nvm_prog_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          busy,
  output logic          launch,
  output space_e        launch_space
);
  logic       armed_q;
  logic [3:0] nib;
  logic       accept;

  assign nib    = ctl_wdata[CW-1 -: 4];
  assign accept = ctl_we && !busy;

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (accept) armed_q <= (nib == KEY_ARM);
  end

  assign launch       = accept && armed_q && (nib == KEY_GO);
  assign launch_space = space_e'(ctl_wdata[1:0]);

  p_arm_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(ctl_we && ctl_wdata[CW-1 -: 4] == KEY_ARM));
  p_launch_disarms_r2: assert property (@(posedge clk) disable iff (rst)
    launch |=> !armed_q);
endmodule

// File: rtl/nvm_col_latch.sv
module nvm_col_latch #(
  parameter int DW = 8,
  parameter int NB = 128,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] buf_q [NB];
  logic [NB-1:0] valid_vec;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < NB; g++) begin : g_valid
    logic v_q;
    always_ff @(posedge clk) begin
      if (rst || clr)                   v_q <= 1'b0;
      else if (wr_en && wr_idx == g)    v_q <= 1'b1;
    end
    assign valid_vec[g] = v_q;
  end

  assign rd_data  = buf_q[rd_idx];
  assign rd_valid = valid_vec[rd_idx];

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> (valid_vec == '0));
endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_prog_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 11,
  parameter int NB = 128,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  space_e        sp,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    rd_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] user_mem [DEPTH];
  logic [DW-1:0] xrow_mem [NB];
  logic [DW-1:0] sec_q, user_q, xrow_q, sec_rd_q;
  space_e        sel_q;
  logic          user_we;

  assign user_we = we && (sp == SP_USER || sp == SP_ALT);

  always_ff @(posedge clk) begin
    if (user_we) user_mem[waddr] <= wdata;
    user_q <= user_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (we && sp == SP_XROW) xrow_mem[waddr[IW-1:0]] <= wdata;
    xrow_q <= xrow_mem[rd_addr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '1;
      sec_rd_q <= '1;
      sel_q    <= SP_USER;
    end else begin
      if (we && sp == SP_SEC) sec_q <= wdata;
      sec_rd_q <= sec_q;
      sel_q    <= space_e'(rd_sel);
    end
  end

  always_comb begin
    unique case (sel_q)
      SP_XROW: rd_data = xrow_q;
      SP_SEC:  rd_data = sec_rd_q;
      default: rd_data = user_q;
    endcase
  end
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_prog_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 11,
  parameter int PAGE_BYTES = 128,
  parameter int WAIT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DW-1:0]     ld_data,
  input  logic [WAIT_W-1:0] prog_wait,
  input  logic [1:0]        rd_sel,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              busy
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int PW = AW - IW;
  localparam logic [IW-1:0] LAST_IDX = IW'(PAGE_BYTES - 1);

  seq_e              state_q;
  logic              busy_q;
  logic [IW-1:0]     idx_q;
  logic [PW-1:0]     page_q;
  logic [WAIT_W-1:0] wait_q;
  space_e            sp_q;
  logic              launch, ld_ok, clr, mem_we, lat_valid;
  space_e            launch_space;
  logic [DW-1:0]     lat_data;

  assign ld_ok = ld_we && !busy_q;
  assign clr   = (state_q == ST_WAIT) && (wait_q == '0);

  nvm_key_unlock #(.CW(8)) u_key (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .busy(busy_q), .launch(launch), .launch_space(launch_space)
  );

  nvm_col_latch #(.DW(DW), .NB(PAGE_BYTES)) u_latch (
    .clk(clk), .rst(rst), .wr_en(ld_ok), .wr_idx(ld_addr[IW-1:0]),
    .wr_data(ld_data), .clr(clr), .rd_idx(idx_q),
    .rd_data(lat_data), .rd_valid(lat_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)        page_q <= '0;
    else if (ld_ok) page_q <= ld_addr[AW-1:IW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      wait_q  <= '0;
      sp_q    <= SP_USER;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_WRITE;
          busy_q  <= 1'b1;
          idx_q   <= '0;
          sp_q    <= launch_space;
          wait_q  <= prog_wait;
        end
        ST_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_q == '0) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we = (state_q == ST_WRITE) && lat_valid &&
                  (sp_q != SP_SEC || idx_q == '0);

  nvm_store #(.DW(DW), .AW(AW), .NB(PAGE_BYTES)) u_store (
    .clk(clk), .rst(rst), .we(mem_we), .sp(sp_q),
    .waddr({page_q, idx_q}), .wdata(lat_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign busy = busy_q;

  p_launch_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy_q);
  p_busy_tracks_state_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q == (state_q != ST_IDLE));
  p_end_after_wait_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(state_q) == ST_WAIT && $past(wait_q) == '0));
  p_page_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(page_q));
  p_sec_byte0_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && sp_q == SP_SEC) |-> (idx_q == '0));
endmodule

// File: tb/nvm_prog_seq_bench.sv
module nvm_prog_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        ld_we = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [15:0] prog_wait = '0;
  logic [1:0]  rd_sel = '0;
  logic [10:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  nvm_prog_seq u_nvm_prog_seq (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .prog_wait(prog_wait), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  int   bc = 0;
  logic [7:0] sh_user [2048];
  bit         kn_user [2048];
  logic [7:0] sh_xrow [128];
  bit         kn_xrow [128];
  logic [7:0] sh_sec;
  logic [7:0] lat [128];
  bit         lv [128];
  int         pg = 0;

  always @(posedge clk) if (busy) bc++;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic ld(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    if (!busy) begin lat[a[6:0]] = d; lv[a[6:0]] = 1'b1; pg = int'(a[10:7]); end
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_we = 1'b0;
  endtask

  function automatic void commit(input logic [1:0] sp);
    for (int i = 0; i < 128; i++) begin
      if (lv[i]) begin
        if (sp == 2'b01) begin sh_xrow[i] = lat[i]; kn_xrow[i] = 1'b1; end
        else if (sp == 2'b10) begin if (i == 0) sh_sec = lat[0]; end
        else begin sh_user[pg*128+i] = lat[i]; kn_user[pg*128+i] = 1'b1; end
      end
      lv[i] = 1'b0;
    end
  endfunction

  task automatic launch_only(input logic [1:0] sp, input logic [15:0] w);
    prog_wait = w;
    ctl_wr(8'h50);
    ctl_wr({4'hA, 2'b00, sp});
    bc = 0;
    commit(sp);
  endtask

  task automatic busy_wait(input int exp, input string req);
    int guard = 0;
    while (busy && guard < 100000) begin @(negedge clk); guard++; end
    check(req, bc, exp);
  endtask

  task automatic go(input logic [1:0] sp, input logic [15:0] w, input string req);
    launch_only(sp, w);
    check({req, " busy after launch R2"}, int'(busy), 1);
    busy_wait(128 + int'(w) + 1, {req, " busy length R7"});
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [10:0] a,
                        input logic [7:0] e, input string req);
    @(negedge clk); rd_sel = s; rd_addr = a;
    @(negedge clk); check(req, int'(rd_data), int'(e));
  endtask

  task automatic chk_page(input logic [1:0] sp, input int p, input string req);
    for (int i = 0; i < 128; i++) begin
      if (sp == 2'b01) begin
        if (kn_xrow[i]) rd_chk(2'b01, 11'(i), sh_xrow[i], req);
      end else if (kn_user[p*128+i]) begin
        rd_chk(sp, 11'(p*128+i), sh_user[p*128+i], req);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    for (int i = 0; i < 2048; i++) kn_user[i] = 1'b0;
    for (int i = 0; i < 128; i++) begin kn_xrow[i] = 1'b0; lv[i] = 1'b0; end
    sh_sec = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    rd_chk(2'b10, 11'd0, 8'hFF, "R1 security byte reset value");

    // full page of main array, page 3
    for (int i = 0; i < 128; i++) ld(11'(3*128+i), 8'($urandom));
    go(2'b00, 16'd5, "R2 full page");
    chk_page(2'b00, 3, "R10 R2 full page read-back");
    rd_chk(2'b11, 11'(3*128+17), sh_user[3*128+17], "R10 R6 alternate select reads main");

    // partial page: untouched bytes keep old values
    for (int i = 0; i < 20; i++) ld(11'(3*128 + ($urandom % 128)), 8'($urandom));
    go(2'b00, 16'd0, "R4 partial page");
    chk_page(2'b00, 3, "R4 unloaded bytes unchanged");

    // extra row full
    for (int i = 0; i < 128; i++) ld(11'(9*128+i), 8'($urandom));
    go(2'b01, 16'd3, "R6 extra row");
    chk_page(2'b01, 0, "R6 R10 extra row read-back");

    // page chosen by last load
    ld(11'(1*128+4), 8'h11);
    ld(11'(1*128+5), 8'h22);
    ld(11'(7*128+6), 8'h33);
    go(2'b00, 16'd2, "R5 last page");
    rd_chk(2'b00, 11'(7*128+4), 8'h11, "R5 byte moved to last page idx4");
    rd_chk(2'b00, 11'(7*128+6), 8'h33, "R5 last page idx6");

    // key disarm rules
    ctl_wr(8'h50); ctl_wr(8'h30); ctl_wr(8'hA0);
    check("R3 5h,3h,Ah no launch", int'(busy), 0);
    ctl_wr(8'hA0);
    check("R3 lone Ah no launch", int'(busy), 0);
    ctl_wr(8'h50);
    go(2'b00, 16'd1, "R3 5h,5h,Ah launches");
    chk_page(2'b00, 7, "R3 empty launch changes nothing");

    // loads and keys ignored while busy, latches cleared after
    ld(11'(2*128+5), 8'h5A);
    ld(11'(2*128+6), 8'h6B);
    launch_only(2'b00, 16'd60);
    ld(11'(2*128+5), 8'hEE);
    ld(11'(12*128+0), 8'hEE);
    ctl_wr(8'h50);
    busy_wait(128 + 60 + 1, "R7 busy length with wait 60");
    ctl_wr(8'hA1);
    check("R8 key during busy ignored", int'(busy), 0);
    go(2'b01, 16'd0, "R9 launch with empty latch");
    chk_page(2'b01, 0, "R9 extra row unchanged by empty launch");
    rd_chk(2'b00, 11'(2*128+5), 8'h5A, "R8 load during busy ignored");

    // security byte
    ld(11'd0, 8'h3C);
    ld(11'd1, 8'h99);
    go(2'b10, 16'd0, "R6 security");
    rd_chk(2'b10, 11'd0, 8'h3C, "R6 security takes byte 0");
    ld(11'd5, 8'h77);
    go(2'b10, 16'd0, "R6 security no byte0");
    rd_chk(2'b10, 11'd0, 8'h3C, "R6 security unchanged without byte 0");

    // load in the same cycle as the launching write
    prog_wait = 16'd4;
    ctl_wr(8'h50);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'hA0;
    ld_we = 1'b1; ld_addr = 11'(4*128+9); ld_data = 8'hC7;
    lat[9] = 8'hC7; lv[9] = 1'b1; pg = 4;
    @(negedge clk);
    ctl_we = 1'b0; ld_we = 1'b0;
    bc = 0;
    commit(2'b00);
    check("R11 busy after joint launch", int'(busy), 1);
    busy_wait(128 + 4 + 1, "R11 R7 busy length");
    rd_chk(2'b00, 11'(4*128+9), 8'hC7, "R11 simultaneous load written");

    // constrained random rounds
    for (int r = 0; r < 8; r++) begin
      int p, n;
      logic [1:0] sp;
      logic [15:0] w;
      p  = int'($urandom % 16);
      n  = 1 + int'($urandom % 30);
      sp = (r % 3 == 0) ? 2'b01 : ((r % 3 == 1) ? 2'b00 : 2'b11);
      w  = 16'($urandom % 20);
      for (int k = 0; k < n; k++) ld(11'(p*128 + ($urandom % 128)), 8'($urandom));
      go(sp, w, "R4 random round");
      chk_page(sp, p, "R4 R5 random round contents");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule